// File: doc/BRIEF.md
# Bit-Serial NAND Emulation Engine

This block is a minimal programmable machine that evaluates any gate-level netlist one two-input NAND at a time. Every state bit and wire value of the emulated circuit lives in a single long recirculating bit store that advances one position per clock. Two single-bit operand registers feed the one shared NAND gate. The store is the only memory, so a netlist of any shape fits as long as its state and wires fit in the store.

An external sequencer supplies a control word on every clock. One field says whether the bit now leaving the store is captured into the left operand, the right operand, both, or neither. The other field picks the bit that enters the store: the leaving bit itself, a constant, an external data pin, or the NAND of the operands. A store slot therefore comes back into view once every DEPTH cycles. A program is a schedule of control words laid over those slots. The leaving bit and the live NAND value are driven on pins for serial readout.

Top module: `nand_emu_engine`

## Requirements
- R1: A synchronous active-high `rst` clears every store bit and both operand registers. In the first cycle after release, `tap_out` is 0 and `nand_out` is 1.
- R2: The store moves one position per clock. `tap_out` always shows the bit leaving it. A bit written in cycle t appears on `tap_out` in cycle t+DEPTH. Write-source code 000 writes the leaving bit back, so the contents are kept.
- R3: Capture field `cap_sel` works as follows: 00 leaves both operands alone, 01 loads `tap_out` into the left operand, 10 loads it into the right operand and 11 loads it into both. A loaded value is in effect from the next cycle.
- R4: Write-source code 001 writes 0, code 010 writes 1 and code 011 writes `ext_in`.
- R5: Write-source code 100 writes the NAND of the operand values held at the start of the cycle. It does not use an operand that is being captured in that same cycle.
- R6: Write-source codes 101, 110 and 111 behave exactly like 000.
- R7: `nand_out` is always the NAND of the two operand registers.
- R8: A control program that injects a, b and cin into store slots and then evaluates nine NAND gates produces the one-bit full-adder sum and carry in their slots, for all eight input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cap_sel | input | 2 | Operand capture select (bit 0 left, bit 1 right) |
| src_sel | input | 3 | Write-source select for the store input |
| ext_in | input | 1 | External data bit for injecting primary inputs |
| tap_out | output | 1 | Bit currently leaving the store |
| nand_out | output | 1 | NAND of the two operand registers |

## Verification
The bench first writes a slot with the NAND while capturing into the operands in the same cycle. A design that forwarded the captured bit would store the wrong value, and the slot read back one pass later shows it. It drives every reserved write code and then reads the store back. This exposes a decoder that treats those codes as a constant or as the NAND. A full-adder program runs over all eight input combinations and checks the sum and carry slots. That run catches an off-by-one store depth, because the program would then lose its slot alignment. It also catches operand capture from the wrong store end or swapped capture bits.

// File: rtl/nemu_pkg.sv
package nemu_pkg;
   typedef enum logic [1:0] {
      CAP_NONE  = 2'b00,
      CAP_LEFT  = 2'b01,
      CAP_RIGHT = 2'b10,
      CAP_BOTH  = 2'b11
   } cap_e;

   typedef enum logic [2:0] {
      SRC_KEEP = 3'd0,
      SRC_ZERO = 3'd1,
      SRC_ONE  = 3'd2,
      SRC_EXT  = 3'd3,
      SRC_NAND = 3'd4
   } src_e;

   localparam int CAP_W = 2;
   localparam int SRC_W = 3;
endpackage

// File: rtl/nemu_store.sv
module nemu_store #(
   parameter int DEPTH = 880
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic head,
   output logic second,
   output logic tail
);
   localparam int LAST = DEPTH - 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("nemu_store: DEPTH must be at least 2");
      end else begin : g_ring
         logic [LAST:0] ring;

         always_ff @(posedge clk) begin
            if (rst) ring <= '0;
            else     ring <= {ring[LAST-1:0], din};
         end

         assign head   = ring[0];
         assign second = ring[1];
         assign tail   = ring[LAST];
      end
   endgenerate
endmodule

// File: rtl/nemu_operands.sv
module nemu_operands
   import nemu_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [CAP_W-1:0] cap,
   input  logic             tap,
   output logic             op_l,
   output logic             op_r,
   output logic             nand_o
);
   logic [1:0] ops;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_op
         always_ff @(posedge clk) begin
            if (rst)         ops[i] <= 1'b0;
            else if (cap[i]) ops[i] <= tap;
         end
      end
   endgenerate

   assign op_l   = ops[0];
   assign op_r   = ops[1];
   assign nand_o = ~(ops[0] & ops[1]);
endmodule

// File: rtl/nemu_wsel.sv
module nemu_wsel
   import nemu_pkg::*;
(
   input  logic [SRC_W-1:0] src,
   input  logic             tap,
   input  logic             nand_i,
   input  logic             ext,
   output logic             wbit
);
   always_comb begin
      unique case (src)
         SRC_ZERO: wbit = 1'b0;
         SRC_ONE:  wbit = 1'b1;
         SRC_EXT:  wbit = ext;
         SRC_NAND: wbit = nand_i;
         default:  wbit = tap;
      endcase
   end
endmodule

// File: rtl/nand_emu_engine.sv
module nand_emu_engine
   import nemu_pkg::*;
#(
   parameter int DEPTH = 880
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CAP_W-1:0] cap_sel,
   input  logic [SRC_W-1:0] src_sel,
   input  logic             ext_in,
   output logic             tap_out,
   output logic             nand_out
);
   logic st_head, st_second, st_tail;
   logic op_left, op_right, nand_w;
   logic wbit;

   nemu_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst(rst), .din(wbit),
      .head(st_head), .second(st_second), .tail(st_tail)
   );

   nemu_operands u_ops (
      .clk(clk), .rst(rst), .cap(cap_sel), .tap(st_tail),
      .op_l(op_left), .op_r(op_right), .nand_o(nand_w)
   );

   nemu_wsel u_wsel (
      .src(src_sel), .tap(st_tail), .nand_i(nand_w),
      .ext(ext_in), .wbit(wbit)
   );

   assign tap_out  = st_tail;
   assign nand_out = nand_w;
endmodule

// File: rtl/nemu_engine_chk.sv
module nemu_engine_chk #(
   parameter int DEPTH = 880
) (
   input logic       clk,
   input logic       rst,
   input logic [1:0] cap_sel,
   input logic [2:0] src_sel,
   input logic       ext_in,
   input logic       tap_out,
   input logic       nand_out,
   input logic       op_l,
   input logic       op_r,
   input logic       head,
   input logic       second
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!tap_out && nand_out && !op_l && !op_r));

   // R2
   shift_step_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (second == $past(head)));

   // R3
   cap_left_chk: assert property (@(posedge clk) disable iff (rst)
      cap_sel[0] |=> (op_l == $past(tap_out)));

   // R3
   hold_left_chk: assert property (@(posedge clk) disable iff (rst)
      !cap_sel[0] |=> $stable(op_l));

   // R3
   cap_right_chk: assert property (@(posedge clk) disable iff (rst)
      cap_sel[1] |=> (op_r == $past(tap_out)));

   // R3
   hold_right_chk: assert property (@(posedge clk) disable iff (rst)
      !cap_sel[1] |=> $stable(op_r));

   // R4
   write_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (src_sel == 3'd1) |=> !head);

   // R4
   write_one_chk: assert property (@(posedge clk) disable iff (rst)
      (src_sel == 3'd2) |=> head);

   // R4
   write_ext_chk: assert property (@(posedge clk) disable iff (rst)
      (src_sel == 3'd3) |=> (head == $past(ext_in)));

   // R5
   write_nand_chk: assert property (@(posedge clk) disable iff (rst)
      (src_sel == 3'd4) |=> (head == $past(nand_out)));

   // R2 R6
   write_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (src_sel == 3'd0 || src_sel > 3'd4) |=> (head == $past(tap_out)));
endmodule

bind nand_emu_engine nemu_engine_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst(rst), .cap_sel(cap_sel), .src_sel(src_sel),
   .ext_in(ext_in), .tap_out(tap_out), .nand_out(nand_out),
   .op_l(op_left), .op_r(op_right), .head(st_head), .second(st_second)
);

// File: tb/nand_emu_engine_test.sv
module nand_emu_engine_test;
   localparam int D = 880;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] cap_sel = 2'b00;
   logic [2:0] src_sel = 3'd0;
   logic       ext_in = 1'b0;
   logic       tap_out, nand_out;

   int n_checks = 0;
   int n_fails  = 0;

   logic  mring [D];
   logic  ml, mr;
   logic [1:0] exp_q [$];
   string      tag_q [$];

   always #2.5 clk = ~clk;

   nand_emu_engine #(.DEPTH(D)) uut (
      .clk(clk), .rst(rst), .cap_sel(cap_sel), .src_sel(src_sel),
      .ext_in(ext_in), .tap_out(tap_out), .nand_out(nand_out)
   );

   task automatic check(input logic act, input logic expv, input string tag);
      n_checks++;
      if (act !== expv) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, expv);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < D; i++) mring[i] = 1'b0;
      ml = 1'b0; mr = 1'b0;
   endtask

   // driver: called at a negedge, leaves at the next negedge
   task automatic apply(input logic [1:0] c, input logic [2:0] w,
                        input logic e, input string tag);
      logic tb, nb, wb;
      cap_sel = c; src_sel = w; ext_in = e;
      tb = mring[D-1];
      nb = ~(ml & mr);
      exp_q.push_back({tb, nb});
      tag_q.push_back(tag);
      case (w)
         3'd1:    wb = 1'b0;
         3'd2:    wb = 1'b1;
         3'd3:    wb = e;
         3'd4:    wb = nb;
         default: wb = tb;
      endcase
      if (c[0]) ml = tb;
      if (c[1]) mr = tb;
      for (int i = D-1; i > 0; i--) mring[i] = mring[i-1];
      mring[0] = wb;
      @(negedge clk);
   endtask

   // monitor: compares between edges
   always @(negedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         logic [1:0] ex;
         string t;
         ex = exp_q.pop_front();
         t  = tag_q.pop_front();
         n_checks++;
         if ({tap_out, nand_out} !== ex) begin
            n_fails++;
            $display("FAIL %s: tap/nand actual %b%b expected %b", t,
                     tap_out, nand_out, ex);
         end
      end
   end

   task automatic do_reset();
      rst = 1'b1;
      cap_sel = 2'b00; src_sel = 3'd0; ext_in = 1'b0;
      repeat (3) @(negedge clk);
      model_clear();
      rst = 1'b0;
   endtask

   task automatic keep_pass(input string tag);
      for (int s = 0; s < D; s++) apply(2'b00, 3'd0, 1'b0, tag);
   endtask

   // one NAND gate: slots x,y read into operands, result written to slot z
   task automatic gate_pass(input int x, input int y, input int z);
      for (int s = 0; s < D; s++) begin
         logic [1:0] c;
         c = {(s == y), (s == x)};
         apply(c, (s == z) ? 3'd4 : 3'd0, 1'b0, "R8");
      end
   endtask

   task automatic adder_vector(input logic a, input logic b, input logic ci);
      logic sum_e, co_e;
      for (int s = 0; s < D; s++) begin
         if (s == 0)      apply(2'b00, 3'd3, a,  "R8");
         else if (s == 1) apply(2'b00, 3'd3, b,  "R8");
         else if (s == 2) apply(2'b00, 3'd3, ci, "R8");
         else             apply(2'b00, 3'd0, 1'b0, "R8");
      end
      gate_pass(0, 1, 10);    // n1 = ~(a&b)
      gate_pass(0, 10, 11);   // n2
      gate_pass(1, 10, 12);   // n3
      gate_pass(11, 12, 13);  // a^b
      gate_pass(13, 2, 14);   // n4
      gate_pass(13, 14, 15);  // n5
      gate_pass(2, 14, 16);   // n6
      gate_pass(15, 16, 17);  // sum
      gate_pass(14, 10, 18);  // carry
      sum_e = a ^ b ^ ci;
      co_e  = (a & b) | (ci & (a ^ b));
      for (int s = 0; s < D; s++) begin
         if (s == 17) begin #1; check(tap_out, sum_e, "R8 sum"); end
         if (s == 18) begin #1; check(tap_out, co_e,  "R8 carry"); end
         apply(2'b00, 3'd0, 1'b0, "R8");
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      model_clear();
      @(negedge clk);
      do_reset();
      #1;
      // R1 reset state
      check(tap_out,  1'b0, "R1 tap");
      check(nand_out, 1'b1, "R1 nand");
      keep_pass("R1 R2");

      // R5 same-cycle capture does not feed the NAND
      for (int s = 0; s < D; s++)
         apply(2'b00, (s < 2) ? 3'd2 : 3'd0, 1'b0, "R4");
      for (int s = 0; s < D; s++) begin
         if (s == 1) begin #1; check(nand_out, 1'b0, "R3 R7 both captured"); end
         if (s == 0)      apply(2'b11, 3'd4, 1'b0, "R5");
         else if (s == 1) apply(2'b00, 3'd4, 1'b0, "R5");
         else             apply(2'b00, 3'd0, 1'b0, "R5");
      end
      for (int s = 0; s < D; s++) begin
         if (s == 0) begin #1; check(tap_out, 1'b1, "R5 old operands"); end
         if (s == 1) begin #1; check(tap_out, 1'b0, "R5 new operands"); end
         apply(2'b00, 3'd0, 1'b0, "R2");
      end

      // R4 constant and external sources, then R2 readback
      for (int s = 0; s < D; s++) begin
         case (s % 3)
            0:       apply(2'b00, 3'd2, 1'b0, "R4");
            1:       apply(2'b00, 3'd1, 1'b0, "R4");
            default: apply(2'b00, 3'd3, s[2], "R4");
         endcase
      end
      keep_pass("R2");

      // R6 reserved codes keep contents
      for (int s = 0; s < D; s++)
         apply(2'b00, 3'd5 + 3'(s % 3), 1'b1, "R6");
      for (int s = 0; s < D; s++) begin
         if (s == 3) begin #1; check(tap_out, 1'b1, "R6 slot3"); end
         if (s == 4) begin #1; check(tap_out, 1'b0, "R6 slot4"); end
         apply(2'b00, 3'd0, 1'b0, "R6");
      end

      // R3 R7 mixed captures with NAND write-back
      for (int s = 0; s < D; s++)
         apply(2'(s % 4), (s % 2 == 1) ? 3'd4 : 3'd0, 1'b0, "R3 R7");
      keep_pass("R3");

      // R8 full adder, all input combinations
      for (int v = 0; v < 8; v++)
         adder_vector(v[2], v[1], v[0]);

      // R1 reset mid-run
      do_reset();
      #1;
      check(tap_out,  1'b0, "R1 re-reset tap");
      check(nand_out, 1'b1, "R1 re-reset nand");
      apply(2'b00, 3'd0, 1'b0, "R1");
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule